// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a single-channel serial peripheral interface master. It sends one transmit word and collects one receive word in the same frame over a serial clock, a data-out line and a data-in line, and it drives one chip-select line. The system clock feeds a programmable divider, and the divider produces the serial clock. A one-cycle start request launches a frame. Before that request the surrounding logic sets the clock polarity, the clock phase, the frame length, the bit order and the active level of chip-select.

All configuration is sampled at the start request and held for the whole frame. While a frame is running, a second start request and any change on the configuration inputs have no effect. The received word comes out right-aligned and zero-extended. A one-cycle done strobe marks the end of the frame, and the busy flag is high for the whole frame.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, and whenever no frame is running, `busy` and `done` are 0, `mosi` is 0 and `sclk` equals the live `cfg_cpol`. After reset `rx_word` is 0. During a frame `sclk` starts at the polarity level and is back at that level when the frame ends.
- R2: Modes follow the usual mapping: mode 0 is cpol=0/cpha=0, mode 1 is 0/1, mode 2 is 1/0 and mode 3 is 1/1. With cpha=0 the master samples `miso` on the first `sclk` edge of each bit and moves `mosi` on the second edge. With cpha=1 it moves `mosi` on the first edge and samples on the second. Modes 0 and 3 therefore sample on rising edges, and modes 1 and 2 sample on falling edges.
- R3: Every `sclk` half period lasts `cfg_div`+1 system clock cycles. Chip-select is active for exactly one half period before the first `sclk` edge and for exactly one half period after the last edge.
- R4: The frame length is `cfg_len` bits. Values below 4 are treated as 4 and values above 32 are treated as 32. A frame of L bits has exactly 2·L `sclk` edges.
- R5: When `cfg_lsb_first`=0, bit L-1 of `tx_word` goes out first and the first received bit lands in bit L-1 of `rx_word`. When `cfg_lsb_first`=1, bit 0 goes out first and the first received bit lands in bit 0.
- R6: During a frame `cs` holds the level given by `cfg_cs_high` (1 means active high). Outside a frame it holds the opposite of the live `cfg_cs_high`.
- R7: The frame is full duplex, with one bit in each direction per `sclk` cycle. `rx_word` holds the L received bits right-aligned, with bits L and above at 0. It is updated when `done` rises and is held until the next frame ends.
- R8: `busy` is 1 from the cycle after an accepted start until chip-select deasserts. `done` is high for exactly one cycle, the cycle in which `cs` returns to inactive and `busy` falls.
- R9: A start request that arrives while `busy` is 1 is ignored. The running frame is not disturbed and no second frame follows it.
- R10: Every configuration input and `tx_word` is sampled in the cycle the start request is accepted. Changes to them later in the frame do not alter the frame.
- R11: In the first cycle `cs` is active, before any `sclk` edge, `mosi` already carries the first bit of the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame launch request, one cycle |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on first edge, 1: sample on second edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_cs_high | input | 1 | 1: chip-select active high |
| cfg_len | input | 6 | Frame length in bits (clamped to 4..32) |
| cfg_div | input | 8 | Half period minus one, in system clocks |
| tx_word | input | 32 | Word to transmit, right-aligned |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs | output | 1 | Chip-select |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame strobe |
| rx_word | output | 32 | Received word, right-aligned |

## Verification
The hardest case to reach from the ports is a start request, together with changed configuration, that lands in the middle of a running frame. The mode, bit order, length, divider and data all have to survive it, and no second frame may follow it. The directed tasks pulse `start` a chosen number of cycles after launch, with a different word, inverted phase and bit order, a short length and a zero divider. The bench then checks that the bits seen by its slave model, the received word, the edge count and the half-period spacing all match the original settings, and that `busy` stays low afterwards. Wrong-edge sampling is exposed by a slave model that changes `miso` only on the edges where the master must not sample it.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int unsigned MIN_FRAME = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } spim_state_e;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
    logic cs_high;
  } spim_mode_t;

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  assign tick_o = run_i && (cnt_q == div_i);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the half-period counter never passes the captured divider
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= div_i));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int W     = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [W-1:0]     ld_word_i,
  input  logic             ld_lsb_i,
  input  logic [LEN_W-1:0] ld_len_i,
  input  logic             advance_i,
  input  logic             sample_i,
  input  logic             miso_i,
  output logic             mosi_o,
  output logic [W-1:0]     rx_word_o
);

  localparam logic [LEN_W:0] WIDTH_V = (LEN_W+1)'(W);

  logic [W-1:0]     tx_q, tx_d;
  logic [W-1:0]     rx_q, rx_d;
  logic             lsb_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W:0]   ld_gap;
  logic [LEN_W:0]   op_gap;

  assign ld_gap = WIDTH_V - {1'b0, ld_len_i};
  assign op_gap = WIDTH_V - {1'b0, len_q};

  always_comb begin
    tx_d = tx_q;
    if (load_i) begin
      if (ld_lsb_i) tx_d = ld_word_i;
      else          tx_d = ld_word_i << ld_gap;
    end else if (advance_i) begin
      if (lsb_q) tx_d = tx_q >> 1;
      else       tx_d = tx_q << 1;
    end
  end

  always_comb begin
    rx_d = rx_q;
    if (load_i) begin
      rx_d = '0;
    end else if (sample_i) begin
      if (lsb_q) rx_d = {miso_i, rx_q[W-1:1]};
      else       rx_d = {rx_q[W-2:0], miso_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q <= 1'b0;
      len_q <= LEN_W'(W);
    end else if (load_i) begin
      lsb_q <= ld_lsb_i;
      len_q <= ld_len_i;
    end
  end

  assign mosi_o    = lsb_q ? tx_q[0] : tx_q[W-1];
  assign rx_word_o = lsb_q ? (rx_q >> op_gap) : rx_q;

  // R2: a single edge either moves the output bit or samples the input, never both
  a_r2_edge_role: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance_i && sample_i));

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int MAX_BITS = 32,
  parameter int DIV_W    = 8,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_lsb_first,
  input  logic                cfg_cs_high,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic                cs,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] rx_word
);
  import spim_pkg::*;

  localparam int             ECNT_W  = LEN_W + 1;
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BITS);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  // state and captured configuration
  spim_state_e            state_q, state_d;
  spim_mode_t             mode_q, mode_d;
  logic [LEN_W-1:0]       len_q, len_d;
  logic [DIV_W-1:0]       div_q, div_d;
  logic                   sclk_q, sclk_d;
  logic [ECNT_W-1:0]      ecnt_q, ecnt_d;
  logic                   done_q, done_d;
  logic [MAX_BITS-1:0]    rx_q, rx_d;

  logic                   run, load, tick;
  logic                   edge_fire, finish, edge_even;
  logic                   sample, advance;
  logic [ECNT_W-1:0]      end_cnt;
  logic [LEN_W-1:0]       len_clamped;
  logic                   sh_mosi;
  logic [MAX_BITS-1:0]    sh_rx;

  always_comb begin
    if (cfg_len < LEN_MIN)      len_clamped = LEN_MIN;
    else if (cfg_len > LEN_MAX) len_clamped = LEN_MAX;
    else                        len_clamped = cfg_len;
  end

  assign run       = (state_q == ST_RUN);
  assign load      = start && !run;
  assign end_cnt   = {len_q, 1'b0};
  assign edge_fire = tick && (ecnt_q != end_cnt);
  assign finish    = tick && (ecnt_q == end_cnt);
  assign edge_even = ~ecnt_q[0];
  assign sample    = edge_fire && (mode_q.cpha ? !edge_even : edge_even);
  assign advance   = edge_fire && (mode_q.cpha ? (edge_even && (ecnt_q != '0))
                                               : !edge_even);

  spim_baud #(
    .DIV_W (DIV_W)
  ) u_baud (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spim_shifter #(
    .W     (MAX_BITS),
    .LEN_W (LEN_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (load),
    .ld_word_i (tx_word),
    .ld_lsb_i  (cfg_lsb_first),
    .ld_len_i  (len_clamped),
    .advance_i (advance),
    .sample_i  (sample),
    .miso_i    (miso),
    .mosi_o    (sh_mosi),
    .rx_word_o (sh_rx)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    len_d   = len_q;
    div_d   = div_q;
    sclk_d  = sclk_q;
    ecnt_d  = ecnt_q;
    rx_d    = rx_q;
    done_d  = 1'b0;
    if (load) begin
      state_d        = ST_RUN;
      mode_d.cpol    = cfg_cpol;
      mode_d.cpha    = cfg_cpha;
      mode_d.lsb_first = cfg_lsb_first;
      mode_d.cs_high = cfg_cs_high;
      len_d          = len_clamped;
      div_d          = cfg_div;
      sclk_d         = cfg_cpol;
      ecnt_d         = '0;
    end else if (edge_fire) begin
      sclk_d = ~sclk_q;
      ecnt_d = ecnt_q + ECNT_W'(1);
    end else if (finish) begin
      state_d = ST_IDLE;
      rx_d    = sh_rx;
      done_d  = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      ecnt_q  <= '0;
      done_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      ecnt_q  <= ecnt_d;
      done_q  <= done_d;
      rx_q    <= rx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= '0;
      len_q  <= LEN_MAX;
      div_q  <= '0;
    end else if (load) begin
      mode_q <= mode_d;
      len_q  <= len_d;
      div_q  <= div_d;
    end
  end

  // outputs
  assign busy    = run;
  assign done    = done_q;
  assign rx_word = rx_q;
  assign sclk    = run ? sclk_q : cfg_cpol;
  assign cs      = run ? mode_q.cs_high : ~cfg_cs_high;
  assign mosi    = run ? sh_mosi : 1'b0;

  // R8: end-of-frame strobe lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_q |=> !done_q);

  // R8: strobe coincides with the end of busy
  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_q |-> (!run && $past(run)));

  // R6: chip-select does not move inside a frame
  a_r6_cs_steady: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run && $past(run)) |-> $stable(cs));

  // R9/R10: a request while busy leaves the captured frame settings alone
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run && start) |=> ($stable(len_q) && $stable(mode_q) && $stable(div_q)));

  // R4: edge count stays within twice the frame length
  a_r4_edge_bound: assert property (@(posedge clk) disable iff (!rst_int_n)
    run |-> (ecnt_q <= end_cnt));

  // R1: the serial clock is back at its idle level when a frame ends
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(run) |-> (sclk_q == mode_q.cpol));

endmodule

// File: tb/spi_frame_master_bench.sv
`timescale 1ns/1ps
module spi_frame_master_bench;

  localparam int W  = 32;
  localparam int LW = 6;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_cs_high = 1'b0;
  logic [LW-1:0] cfg_len = 6'd8;
  logic [DW-1:0] cfg_div = 8'd0;
  logic [W-1:0]  tx_word = '0;
  logic          miso;
  logic          sclk, mosi, cs, busy, done;
  logic [W-1:0]  rx_word;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // slave model and monitor state
  bit         in_frame = 1'b0;
  bit         b_cpol, b_cpha, b_lsb, b_cshi;
  int         b_len = 8;
  logic [W-1:0] s_word = '0;
  logic [W-1:0] s_rx = '0;
  int         s_idx = 0, s_shift_n = 0, s_bits = 0;
  int         edges = 0, last_edge_cyc = 0, first_edge_cyc = 0;
  int         min_gap = 0, max_gap = 0;
  int         cs_on_cyc = 0, cs_off_cyc = 0;
  logic       sclk_prev = 1'b0, cs_prev = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc++;

  spi_frame_master u_spi_frame_master (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cfg_cpol      (cfg_cpol),
    .cfg_cpha      (cfg_cpha),
    .cfg_lsb_first (cfg_lsb_first),
    .cfg_cs_high   (cfg_cs_high),
    .cfg_len       (cfg_len),
    .cfg_div       (cfg_div),
    .tx_word       (tx_word),
    .miso          (miso),
    .sclk          (sclk),
    .mosi          (mosi),
    .cs            (cs),
    .busy          (busy),
    .done          (done),
    .rx_word       (rx_word)
  );

  function automatic logic slave_bit(input logic [W-1:0] word, input int idx,
                                     input int len, input bit lsb);
    if (idx < 0 || idx >= len) return 1'b0;
    return lsb ? word[idx] : word[len-1-idx];
  endfunction

  assign miso = in_frame ? slave_bit(s_word, s_idx, b_len, b_lsb) : 1'b0;

  always @(sclk or cs) begin
    if (cs !== cs_prev && in_frame) begin
      if (cs === b_cshi) begin
        cs_on_cyc = cyc;
        edges = 0; s_idx = 0; s_shift_n = 0; s_bits = 0; s_rx = '0;
        min_gap = 1000000; max_gap = 0;
      end else begin
        cs_off_cyc = cyc;
      end
    end
    if (sclk !== sclk_prev && in_frame) begin
      if (edges == 0) first_edge_cyc = cyc;
      else begin
        if (cyc - last_edge_cyc < min_gap) min_gap = cyc - last_edge_cyc;
        if (cyc - last_edge_cyc > max_gap) max_gap = cyc - last_edge_cyc;
      end
      last_edge_cyc = cyc;
      edges++;
      if (sclk === ~(b_cpol ^ b_cpha)) begin
        if (b_lsb) s_rx[s_bits] = mosi;
        else       s_rx = {s_rx[W-2:0], mosi};
        s_bits++;
      end else begin
        if (!(b_cpha && s_shift_n == 0)) s_idx++;
        s_shift_n++;
      end
    end
    cs_prev = cs;
    sclk_prev = sclk;
  end

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one frame with full checking; poke >= 0 pulses start and scrambles config mid-frame
  task automatic frame(input int mode, input int len_req, input bit lsb, input bit cshi,
                       input int div, input logic [W-1:0] txw, input logic [W-1:0] sw,
                       input int poke);
    int eff;
    int n;
    logic [W-1:0] mask;
    logic first_bit;
    eff  = (len_req < 4) ? 4 : ((len_req > 32) ? 32 : len_req);
    mask = (eff == 32) ? '1 : ((32'h1 << eff) - 32'h1);
    b_cpol = mode[1]; b_cpha = mode[0]; b_lsb = lsb; b_cshi = cshi; b_len = eff;
    s_word = sw;
    cfg_cpol = mode[1]; cfg_cpha = mode[0]; cfg_lsb_first = lsb; cfg_cs_high = cshi;
    cfg_len = LW'(len_req); cfg_div = DW'(div); tx_word = txw;
    @(negedge clk);
    in_frame = 1'b1;
    first_bit = lsb ? txw[0] : txw[eff-1];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R8 busy after start", W'(busy), 32'h1);
    check(cs === cshi, "R6 cs active level", W'(cs), W'(cshi));
    check(mosi === first_bit, "R11 first bit before first edge", W'(mosi), W'(first_bit));
    check(sclk === mode[1], "R1 sclk at polarity before edges", W'(sclk), W'(mode[1]));
    if (poke >= 0) begin
      repeat (poke) @(negedge clk);
      start = 1'b1;
      tx_word = ~txw;
      cfg_cpha = ~cfg_cpha;
      cfg_lsb_first = ~cfg_lsb_first;
      cfg_len = 6'd5;
      cfg_div = 8'd0;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done === 1'b1, "R8 done strobe seen", W'(done), 32'h1);
    check(busy === 1'b0 && cs === ~cshi, "R8 busy/cs drop with done",
          W'({busy, cs}), W'({1'b0, ~cshi}));
    check(rx_word === (sw & mask), "R7/R5/R2 received word", rx_word, sw & mask);
    check(s_rx === (txw & mask), "R5/R2/R10 bits seen by slave", s_rx, txw & mask);
    check(edges == 2 * eff, "R4 edge count", W'(edges), W'(2 * eff));
    check(min_gap == div + 1 && max_gap == div + 1, "R3 half period",
          W'({min_gap[15:0], max_gap[15:0]}), W'({16'(div + 1), 16'(div + 1)}));
    check(first_edge_cyc - cs_on_cyc == div + 1, "R3 cs lead",
          W'(first_edge_cyc - cs_on_cyc), W'(div + 1));
    check(cs_off_cyc - last_edge_cyc == div + 1, "R3 cs lag",
          W'(cs_off_cyc - last_edge_cyc), W'(div + 1));
    check(sclk === cfg_cpol, "R1 sclk idle after frame", W'(sclk), W'(cfg_cpol));
    @(negedge clk);
    check(done === 1'b0, "R8 done one cycle", W'(done), 32'h0);
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && rx_word === (sw & mask), "R9/R7 no second frame, word held",
          W'(busy), 32'h0);
    in_frame = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cfg_cpol = 1'b1; cfg_cs_high = 1'b0;
    repeat (3) @(negedge clk);
    check(sclk === 1'b1, "R1 reset sclk follows cpol=1", W'(sclk), 32'h1);
    check(cs === 1'b1, "R6 reset cs inactive (active low)", W'(cs), 32'h1);
    check(busy === 1'b0 && done === 1'b0 && mosi === 1'b0, "R1 reset flags",
          W'({busy, done, mosi}), 32'h0);
    check(rx_word === '0, "R1 reset rx_word", rx_word, 32'h0);
    cfg_cpol = 1'b0; cfg_cs_high = 1'b1;
    @(negedge clk);
    check(sclk === 1'b0 && cs === 1'b0, "R1/R6 idle follows live config",
          W'({sclk, cs}), 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(busy === 1'b0, "R1 idle after reset release", W'(busy), 32'h0);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++)
      frame(m, 8, 1'b0, 1'b0, 1, 32'hA5 ^ W'(m * 17), 32'h3C ^ W'(m * 29), -1);
  endtask

  task automatic t_lengths();
    frame(0, 4, 1'b0, 1'b0, 0, 32'h0000_0009, 32'h0000_0006, -1);
    frame(3, 32, 1'b0, 1'b0, 0, 32'hDEAD_BEEF, 32'h1234_5678, -1);
    frame(1, 13, 1'b0, 1'b0, 2, 32'h0000_1ACE, 32'h0000_0B3D, -1);
    frame(2, 2, 1'b0, 1'b0, 1, 32'hFFFF_FFFB, 32'hFFFF_FFF5, -1);   // R4 clamp low
    frame(0, 40, 1'b1, 1'b0, 0, 32'h8001_F00D, 32'hC0DE_0003, -1);  // R4 clamp high
  endtask

  task automatic t_order();
    frame(0, 12, 1'b1, 1'b0, 1, 32'h0000_0A31, 32'h0000_05C8, -1);
    frame(3, 12, 1'b1, 1'b0, 2, 32'h0000_0E01, 32'h0000_0107, -1);
    frame(1, 7, 1'b1, 1'b0, 0, 32'h0000_0041, 32'h0000_0022, -1);
  endtask

  task automatic t_cs_polarity();
    frame(1, 9, 1'b0, 1'b1, 1, 32'h0000_0155, 32'h0000_00AA, -1);
    frame(2, 6, 1'b1, 1'b1, 3, 32'h0000_0021, 32'h0000_0012, -1);
  endtask

  task automatic t_divider();
    frame(2, 8, 1'b0, 1'b0, 5, 32'h0000_0096, 32'h0000_0069, -1);
  endtask

  task automatic t_busy_start();
    frame(0, 8, 1'b0, 1'b0, 1, 32'h0000_00C3, 32'h0000_005A, 6);     // R9
  endtask

  task automatic t_cfg_hold();
    frame(3, 16, 1'b1, 1'b0, 2, 32'h0000_B00C, 32'h0000_7E81, 20);   // R10
  endtask

  initial begin
    t_reset();
    t_modes();
    t_lengths();
    t_order();
    t_cs_polarity();
    t_divider();
    t_busy_start();
    t_cfg_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule